// File: doc/BRIEF.md
# Eight-Bit Select-Coded Arithmetic and Logic Unit

This block is a datapath unit. It turns two 8-bit operands and a 3-bit operation code into one 8-bit result. The eight codes give the following results:

- two fixed constants;
- three bitwise combinations of the operands;
- the inversion of the second operand;
- wrapping addition and subtraction.

One shared adder serves both arithmetic codes. Subtraction adds the inverted second operand with a carry-in of one. The adder's ninth bit is exposed as a carry output. For subtraction it reads as "no borrow".

By default the result is purely combinational. It follows the operands and the code within the same evaluation, so a control unit can place the block between register stages. A build parameter can instead add one output register stage for timing closure. That stage clears on reset. The clock and reset pins drive only that optional stage and the built-in checks.

Top module: `sc_alu`

## Requirements
- R1: Operation code 3'b000 drives result to 8'h00 for any operands.
- R2: Code 3'b001 drives result to the bitwise OR of op_a and op_b, and code 3'b010 drives it to their bitwise AND.
- R3: Code 3'b011 drives result to the bitwise exclusive OR of op_a and op_b.
- R4: Code 3'b100 drives result to the bitwise inversion of op_b, and op_a has no effect on result.
- R5: Code 3'b101 drives result to (op_a + op_b) modulo 256.
- R6: Code 3'b110 drives result to (op_a - op_b) modulo 256.
- R7: Code 3'b111 drives result to 8'hFF for any operands.
- R8: carry_out is the ninth sum bit for code 3'b101. For code 3'b110 it is 1 exactly when op_a >= op_b (unsigned). For every other code it is 0.
- R9: With the default build (no output register), result and carry_out follow the inputs combinationally in the same cycle, whether or not rst_n is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low reset for the optional output register |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | 8 | Operation result |
| carry_out | output | 1 | Adder ninth bit for add and subtract codes, else 0 |

## Verification
Each code is swept across every pairing of the operands 0x00, 0x01, 0x7F, 0x80 and 0xFF, followed by over a thousand random pairs. Expected values come from integer arithmetic.

The wrap cases 0xFF+0x01 and 0x00-0x01 catch an adder that saturates or drops the carry-in of one. The pair 0x80-0x80 catches a borrow flag that is inverted or off by one at equality. The inversion code is run with op_a varied, to expose a design that mixes op_a in. Reset is held while the constant codes are driven, which exposes an output that is wrongly gated by reset.

// File: rtl/sc_alu_pkg.sv
package sc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ZERO = 3'b000,
    OP_OR   = 3'b001,
    OP_AND  = 3'b010,
    OP_XOR  = 3'b011,
    OP_NOTB = 3'b100,
    OP_ADD  = 3'b101,
    OP_SUB  = 3'b110,
    OP_ONES = 3'b111
  } alu_op_e;

  // Ripple-style sum with carry in; returns {carry, sum} of width w+1.
  function automatic logic [16:0] add_carry16(input logic [15:0] a,
                                              input logic [15:0] b,
                                              input logic        cin);
    logic [16:0] acc;
    acc = {1'b0, a} + {1'b0, b} + {16'd0, cin};
    return acc;
  endfunction

endpackage

// File: rtl/sc_alu_adder.sv
module sc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  import sc_alu_pkg::*;

  localparam int PADW = 16 - W;

  logic [W-1:0] b_eff;
  logic [16:0]  wide;

  assign b_eff = b ^ {W{sub}};

  generate
    if (PADW > 0) begin : g_pad
      assign wide = add_carry16({{PADW{1'b0}}, a}, {{PADW{1'b0}}, b_eff}, sub);
    end else begin : g_full
      assign wide = add_carry16(a[15:0], b_eff[15:0], sub);
    end
  endgenerate

  assign sum  = wide[W-1:0];
  assign cout = wide[W];

  // R8: in subtract mode the adder carry must equal "no borrow"
  always_comb begin
    if (sub) begin
      AST_SUB_NO_BORROW: assert (cout == (a >= b) || $isunknown({a, b})); // R8
    end
  end
endmodule

// File: rtl/sc_alu_logic.sv
module sc_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] or_o,
  output logic [W-1:0] and_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] notb_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign or_o[i]   = a[i] | b[i];
    assign and_o[i]  = a[i] & b[i];
    assign xor_o[i]  = a[i] ^ b[i];
    assign notb_o[i] = ~b[i];
  end

  // R3: the XOR lane must agree with OR minus AND
  always_comb begin
    AST_XOR_FROM_OR_AND: assert (xor_o == (or_o & ~and_o) || $isunknown({a, b})); // R3
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] result,
  output logic         carry_out
);
  import sc_alu_pkg::*;

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  alu_op_e      op;
  logic         is_sub;
  logic         is_arith;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] lu_or, lu_and, lu_xor, lu_notb;
  logic [W-1:0] next_result;
  logic         next_carry;

  assign op       = alu_op_e'(op_sel);
  assign is_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  sc_alu_adder #(.W(W)) i_adder (
    .a(op_a), .b(op_b), .sub(is_sub), .sum(add_sum), .cout(add_cout)
  );

  sc_alu_logic #(.W(W)) i_logic (
    .a(op_a), .b(op_b), .or_o(lu_or), .and_o(lu_and),
    .xor_o(lu_xor), .notb_o(lu_notb)
  );

  always_comb begin
    unique case (op)
      OP_ZERO: next_result = '0;
      OP_OR:   next_result = lu_or;
      OP_AND:  next_result = lu_and;
      OP_XOR:  next_result = lu_xor;
      OP_NOTB: next_result = lu_notb;
      OP_ADD:  next_result = add_sum;
      OP_SUB:  next_result = add_sum;
      OP_ONES: next_result = ALL_ONES;
      default: next_result = '0;
    endcase
    next_carry = is_arith & add_cout;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result    <= '0;
          carry_out <= 1'b0;
        end else begin
          result    <= next_result;
          carry_out <= next_carry;
        end
      end
    end else begin : g_comb
      assign result    = next_result;
      assign carry_out = next_carry;

      AST_ZERO_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 3'b000 |-> result == '0); // R1
      AST_ONES_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 3'b111 |-> result == ALL_ONES); // R7
      AST_NOTB_IGNORES_A: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 3'b100 |-> (result ^ op_b) == ALL_ONES); // R4
      AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 3'b101 |-> (carry_out == (result < op_a))); // R5
      AST_SUB_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 3'b110 |-> W'(result + op_b) == op_a); // R6
      AST_CARRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_sel == 3'b101 || op_sel == 3'b110) |-> !carry_out); // R8
    end
  endgenerate
endmodule

// File: tb/test_sc_alu.sv
module test_sc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [2:0] op_sel = '0;
  logic [7:0] result;
  logic       carry_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  sc_alu i_sc_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .result(result), .carry_out(carry_out)
  );

  function automatic string req_of(input int code);
    case (code)
      0: return "R1"; 1: return "R2"; 2: return "R2"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic expect_out(input int code, input int a, input int b,
                            output int ey, output int ec);
    ec = 0;
    case (code)
      0: ey = 0;
      1: ey = a | b;
      2: ey = a & b;
      3: ey = a ^ b;
      4: ey = 255 - b;
      5: begin ey = (a + b) % 256; ec = (a + b) > 255; end
      6: begin ey = (a - b + 256) % 256; ec = (a >= b); end
      default: ey = 255;
    endcase
  endtask

  task automatic apply_check(input int code, input int a, input int b);
    int ey, ec;
    @(negedge clk);
    op_sel = code[2:0]; op_a = a[7:0]; op_b = b[7:0];
    #2;
    expect_out(code, a, b, ey, ec);
    checks++;
    if (int'(result) != ey) begin
      fails++;
      $display("FAIL %s: sel=%0d a=%02h b=%02h result actual=%02h expected=%02h",
               req_of(code), code, a, b, result, ey);
    end
    checks++;
    if (int'(carry_out) != ec) begin
      fails++;
      $display("FAIL R8: sel=%0d a=%02h b=%02h carry actual=%0d expected=%0d",
               code, a, b, carry_out, ec);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int corner [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    // R9: outputs follow inputs while reset is still held
    apply_check(7, 8'h12, 8'h34);
    apply_check(0, 8'hAB, 8'hCD);
    apply_check(6, 8'h00, 8'h01);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply_check(c, corner[i], corner[j]);
    // R4: vary op_a with fixed op_b; result must stay ~op_b
    for (int a = 0; a < 256; a += 17) apply_check(4, a, 8'h5A);
    for (int n = 0; n < 1200; n++) begin
      int a, b;
      a = int'($urandom_range(255));
      b = int'($urandom_range(255));
      for (int c = 0; c < 8; c++) apply_check(c, a, b);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule